// File: doc/BRIEF.md
# Multi-Width Wrapping Integer ALU

This block is the integer execution unit of a 64-bit register machine. It takes an operation code, an operation width and two 64-bit operands and returns one 64-bit result. Arithmetic and shift operations run at 8, 16, 32 or 64 bits. Results narrower than 64 bits are zero-extended. Bitwise logic, complement, logical negation, sign extension and three-way compare are also provided.

The caller decides whether the second operand comes from a register or an immediate. The unit sees only the resolved value. The result is captured in one output register, so a result is due one clock after its inputs are applied. A synchronous active-high reset clears that register.

Top module: `alu_int_core`

## Requirements
- R1: While `rst` is high at a rising edge, `result_o` becomes 0. Otherwise `result_o` takes the value computed from the inputs present at that edge, one cycle after they are applied.
- R2: Add (op 0) and subtract (op 1) return `(a ± b) mod 2^w`, zero-extended to 64 bits. The width code selects w: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64.
- R3: Multiply (op 2) returns the low w bits of `a * b`, zero-extended. The width code is as in R2.
- R4: Left shift (op 3) shifts the low w bits of `a` by `b mod w`. Bits shifted out are discarded and the result is zero-extended.
- R5: Logical right shift (op 4) shifts the low w bits of `a`, taken as unsigned, right by `b mod w`. The result is zero-extended.
- R6: Arithmetic right shift (op 5) treats the low w bits of `a` as signed. It shifts them right by `b mod w`, filling with bit w-1, and keeps w bits zero-extended.
- R7: AND (op 6), OR (op 7) and XOR (op 8) act on all 64 bits whatever the width code.
- R8: Complement (op 9) inverts all 64 bits of `a` whatever the width code.
- R9: Logical NOT (op 10) returns 1 when `a` is zero and 0 otherwise.
- R10: Sign extension (op 11) sign-extends the low 8, 16 or 32 bits of `a` to 64 bits for width codes 0, 1 and 2. Width code 3 passes `a` unchanged.
- R11: Compare returns all ones (-1) when a<b, 0 when a=b and 1 when a>b, always over 64 bits. Op 12 compares unsigned and op 13 compares signed.
- R12: Op codes 14 and 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| width_i | input | 2 | Operation width code |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand, register or immediate |
| result_o | output | 64 | Registered result |

## Verification
Every operation has the same latency. Inputs driven on a falling edge are captured at the next rising edge and appear on `result_o` from then on. The bench drives one new operation on each falling edge. On that same falling edge, before driving, it compares `result_o` with the expected value queued for the operation driven one edge earlier. While reset is held, the output is checked against zero at the falling edges.

// File: rtl/alu_int_pkg.sv
package alu_int_pkg;

    localparam int XLEN       = 64;
    localparam int NUM_WIDTHS = 4;
    localparam int OP_BITS    = 4;
    localparam int WCODE_BITS = $clog2(NUM_WIDTHS);

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [OP_BITS-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_MUL  = 4'd2,
        OP_SHL  = 4'd3,
        OP_SHR  = 4'd4,
        OP_SAR  = 4'd5,
        OP_AND  = 4'd6,
        OP_OR   = 4'd7,
        OP_XOR  = 4'd8,
        OP_INV  = 4'd9,
        OP_LNOT = 4'd10,
        OP_SEXT = 4'd11,
        OP_CMPU = 4'd12,
        OP_CMPS = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

    typedef enum logic [WCODE_BITS-1:0] {
        WID_8  = 2'd0,
        WID_16 = 2'd1,
        WID_32 = 2'd2,
        WID_64 = 2'd3
    } alu_width_e;

    // Results of every width lane, already zero-extended
    typedef struct packed {
        word_t sum;
        word_t diff;
        word_t prod;
    } arith_res_t;

    typedef struct packed {
        word_t shl;
        word_t shr;
        word_t sar;
    } shift_res_t;

    typedef struct packed {
        word_t band;
        word_t bor;
        word_t bxor;
        word_t inv;
        word_t lnot;
        word_t sext;
        word_t cmpu;
        word_t cmps;
    } misc_res_t;

    function automatic word_t order_code(input logic less, input logic equal);
        word_t r;
        if (less)       r = '1;
        else if (equal) r = '0;
        else            r = word_t'(1);
        return r;
    endfunction

    function automatic word_t sign_extend(input word_t v, input alu_width_e w);
        word_t r;
        unique case (w)
            WID_8:   r = {{(XLEN-8){v[7]}},   v[7:0]};
            WID_16:  r = {{(XLEN-16){v[15]}}, v[15:0]};
            WID_32:  r = {{(XLEN-32){v[31]}}, v[31:0]};
            default: r = v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alu_int_arith.sv
module alu_int_arith
    import alu_int_pkg::*;
(
    input  word_t      a,
    input  word_t      b,
    input  alu_width_e w,
    output arith_res_t res
);

    word_t sum_l  [NUM_WIDTHS];
    word_t diff_l [NUM_WIDTHS];
    word_t prod_l [NUM_WIDTHS];

    for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_lane
        localparam int LW = 8 << g;
        logic [LW-1:0] s_w, d_w, p_w;
        assign s_w = a[LW-1:0] + b[LW-1:0];
        assign d_w = a[LW-1:0] - b[LW-1:0];
        assign p_w = a[LW-1:0] * b[LW-1:0];
        assign sum_l[g]  = word_t'(s_w);
        assign diff_l[g] = word_t'(d_w);
        assign prod_l[g] = word_t'(p_w);
    end

    always_comb begin
        res.sum  = sum_l[w];
        res.diff = diff_l[w];
        res.prod = prod_l[w];
    end

endmodule

// File: rtl/alu_int_shift.sv
module alu_int_shift
    import alu_int_pkg::*;
(
    input  word_t      a,
    input  word_t      b,
    input  alu_width_e w,
    output shift_res_t res
);

    word_t shl_l [NUM_WIDTHS];
    word_t shr_l [NUM_WIDTHS];
    word_t sar_l [NUM_WIDTHS];

    for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_lane
        localparam int LW = 8 << g;
        localparam int SW = $clog2(LW);
        logic [SW-1:0] amt;
        logic [LW-1:0] l_w, r_w, s_w;
        // amount modulo the lane width: low bits of the power-of-two width
        assign amt = b[SW-1:0];
        assign l_w = a[LW-1:0] << amt;
        assign r_w = a[LW-1:0] >> amt;
        assign s_w = LW'($signed(a[LW-1:0]) >>> amt);
        assign shl_l[g] = word_t'(l_w);
        assign shr_l[g] = word_t'(r_w);
        assign sar_l[g] = word_t'(s_w);
    end

    always_comb begin
        res.shl = shl_l[w];
        res.shr = shr_l[w];
        res.sar = sar_l[w];
    end

endmodule

// File: rtl/alu_int_bitops.sv
module alu_int_bitops
    import alu_int_pkg::*;
(
    input  word_t      a,
    input  word_t      b,
    input  alu_width_e w,
    output misc_res_t  res
);

    logic ult, slt, eq;

    always_comb begin
        ult = a < b;
        slt = $signed(a) < $signed(b);
        eq  = a == b;

        res.band = a & b;
        res.bor  = a | b;
        res.bxor = a ^ b;
        res.inv  = ~a;
        res.lnot = word_t'(a == '0);
        res.sext = sign_extend(a, w);
        res.cmpu = order_code(ult, eq);
        res.cmps = order_code(slt, eq);
    end

endmodule

// File: rtl/alu_int_core.sv
module alu_int_core
    import alu_int_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  op_i,
    input  logic [1:0]  width_i,
    input  logic [63:0] opa_i,
    input  logic [63:0] opb_i,
    output logic [63:0] result_o
);

    alu_op_e    op;
    alu_width_e wid;
    arith_res_t ar;
    shift_res_t sh;
    misc_res_t  mi;
    word_t      next_res;

    assign op  = alu_op_e'(op_i);
    assign wid = alu_width_e'(width_i);

    alu_int_arith  u_arith  (.a(opa_i), .b(opb_i), .w(wid), .res(ar));
    alu_int_shift  u_shift  (.a(opa_i), .b(opb_i), .w(wid), .res(sh));
    alu_int_bitops u_bitops (.a(opa_i), .b(opb_i), .w(wid), .res(mi));

    always_comb begin
        unique case (op)
            OP_ADD:  next_res = ar.sum;
            OP_SUB:  next_res = ar.diff;
            OP_MUL:  next_res = ar.prod;
            OP_SHL:  next_res = sh.shl;
            OP_SHR:  next_res = sh.shr;
            OP_SAR:  next_res = sh.sar;
            OP_AND:  next_res = mi.band;
            OP_OR:   next_res = mi.bor;
            OP_XOR:  next_res = mi.bxor;
            OP_INV:  next_res = mi.inv;
            OP_LNOT: next_res = mi.lnot;
            OP_SEXT: next_res = mi.sext;
            OP_CMPU: next_res = mi.cmpu;
            OP_CMPS: next_res = mi.cmps;
            default: next_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) result_o <= '0;
        else     result_o <= next_res;
    end

    // R1: reset clears the output register
    a_r1_reset_clear: assert property (@(posedge clk) rst |=> result_o == '0);

    // R2: narrow add never sets bits above the lane
    a_r2_narrow_add_zext: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd0 && width_i == 2'd0) |=> result_o[63:8] == '0);

    // R6: narrow arithmetic shift stays inside its lane
    a_r6_sar_zext: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd5 && width_i == 2'd1) |=> result_o[63:16] == '0);

    // R7: XOR of equal operands is zero at every width
    a_r7_xor_self: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd8 && opa_i == opb_i) |=> result_o == '0);

    // R9: logical NOT is a single-bit value
    a_r9_lnot_bool: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd10) |=> result_o[63:1] == '0);

    // R10: byte sign extension fills the upper bits uniformly
    a_r10_sext_fill: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd11 && width_i == 2'd0) |=> (result_o[63:7] == '0 || (&result_o[63:7])));

    // R11: compare yields only -1, 0 or 1, and 0 for equal operands
    a_r11_cmp_range: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd12 || op_i == 4'd13) |=>
        (result_o == '0 || result_o == 64'd1 || result_o == '1));
    a_r11_cmp_equal: assert property (@(posedge clk) disable iff (rst)
        ((op_i == 4'd12 || op_i == 4'd13) && opa_i == opb_i) |=> result_o == '0);

    // R12: spare codes produce zero
    a_r12_spare_zero: assert property (@(posedge clk) disable iff (rst)
        (op_i >= 4'd14) |=> result_o == '0);

endmodule

// File: tb/alu_int_core_tb.sv
module alu_int_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_i = '0;
    logic [1:0]  width_i = '0;
    logic [63:0] opa_i = '0;
    logic [63:0] opb_i = '0;
    logic [63:0] result_o;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    logic [63:0] exp_q [$];
    string       req_q [$];

    always #2.5 clk = ~clk;

    alu_int_core u_dut (
        .clk(clk), .rst(rst), .op_i(op_i), .width_i(width_i),
        .opa_i(opa_i), .opb_i(opb_i), .result_o(result_o)
    );

    function automatic logic [63:0] ref_alu(input logic [3:0] op, input logic [1:0] w,
                                            input logic [63:0] a, input logic [63:0] b);
        int bits;
        int sh;
        logic [63:0] m;
        logic signed [63:0] sa;
        logic signed [63:0] sr;
        bits = 8 << w;
        m  = (bits == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << bits) - 64'd1);
        sh = int'(b % 64'(bits));
        sa = $signed(a << (64 - bits)) >>> (64 - bits);
        sr = sa >>> sh;
        case (op)
            4'd0:  return (a + b) & m;
            4'd1:  return (a - b) & m;
            4'd2:  return (a * b) & m;
            4'd3:  return (a << sh) & m;
            4'd4:  return (a & m) >> sh;
            4'd5:  return sr & m;
            4'd6:  return a & b;
            4'd7:  return a | b;
            4'd8:  return a ^ b;
            4'd9:  return ~a;
            4'd10: return (a == 64'd0) ? 64'd1 : 64'd0;
            4'd11: return (w == 2'd3) ? a : sa;
            4'd12: return (a < b) ? 64'hFFFF_FFFF_FFFF_FFFF : ((a == b) ? 64'd0 : 64'd1);
            4'd13: return ($signed(a) < $signed(b)) ? 64'hFFFF_FFFF_FFFF_FFFF
                          : ((a == b) ? 64'd0 : 64'd1);
            default: return 64'd0;
        endcase
    endfunction

    function automatic string req_name(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:         return "R2";
            4'd2:               return "R3";
            4'd3:               return "R4";
            4'd4:               return "R5";
            4'd5:               return "R6";
            4'd6, 4'd7, 4'd8:   return "R7";
            4'd9:               return "R8";
            4'd10:              return "R9";
            4'd11:              return "R10";
            4'd12, 4'd13:       return "R11";
            default:            return "R12";
        endcase
    endfunction

    task automatic check_val(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called on a falling edge: compare the result due from the previous drive
    task automatic drain_one();
        logic [63:0] e;
        string r;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            r = req_q.pop_front();
            check_val(r, result_o, e);
        end
    endtask

    task automatic step(input logic [3:0] op, input logic [1:0] w,
                        input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        drain_one();
        op_i = op; width_i = w; opa_i = a; opb_i = b;
        exp_q.push_back(ref_alu(op, w, a, b));
        req_q.push_back(req_name(op));
    endtask

    initial begin
        // R1: reset holds the output at zero even with active inputs
        op_i = 4'd9; opa_i = 64'h0; width_i = 2'd3;
        repeat (3) @(negedge clk);
        check_val("R1", result_o, 64'd0);
        rst = 1'b0;

        // R2
        step(4'd0, 2'd0, 64'hFF, 64'h01);
        step(4'd0, 2'd1, 64'h1234_FFFF, 64'h2);
        step(4'd1, 2'd2, 64'h0, 64'h1);
        step(4'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2);
        // R3
        step(4'd2, 2'd0, 64'h10, 64'h10);
        step(4'd2, 2'd2, 64'h1_0001_0003, 64'hFFFF_FFFF);
        step(4'd2, 2'd3, 64'h1_0000_0001, 64'h1_0000_0001);
        // R4, R5: amount taken modulo the width
        step(4'd3, 2'd0, 64'h81, 64'd9);
        step(4'd4, 2'd1, 64'hF_8000, 64'd17);
        step(4'd3, 2'd3, 64'h1, 64'd63);
        // R6
        step(4'd5, 2'd0, 64'h80, 64'd3);
        step(4'd5, 2'd1, 64'h7F00, 64'd4);
        step(4'd5, 2'd3, 64'h8000_0000_0000_0000, 64'd63);
        // R7, R8: width code has no effect
        step(4'd6, 2'd0, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00);
        step(4'd7, 2'd0, 64'hF000_0000_0000_0000, 64'h1);
        step(4'd8, 2'd1, 64'hAAAA_0000_0000_5555, 64'hFFFF_0000_0000_FFFF);
        step(4'd9, 2'd0, 64'h0123_4567_89AB_CDEF, 64'h0);
        // R9
        step(4'd10, 2'd0, 64'h0, 64'h0);
        step(4'd10, 2'd3, 64'h8000_0000_0000_0000, 64'h0);
        // R10
        step(4'd11, 2'd0, 64'hFFFF_0080, 64'h0);
        step(4'd11, 2'd1, 64'h1_7FFF, 64'h0);
        step(4'd11, 2'd2, 64'h8000_0000, 64'h0);
        step(4'd11, 2'd3, 64'h8000_0000, 64'h0);
        // R11
        step(4'd12, 2'd0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF);
        step(4'd13, 2'd0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF);
        step(4'd13, 2'd3, 64'h5, 64'h5);
        step(4'd12, 2'd3, 64'h9, 64'h3);
        // R12
        step(4'd14, 2'd3, 64'hFFFF, 64'h1);
        step(4'd15, 2'd0, 64'hFFFF, 64'h1);

        // Mixed stream: every op and width, one per cycle
        for (int i = 0; i < 400; i++) begin
            step(4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)),
                 {$urandom, $urandom}, (i % 3 == 0) ? 64'($urandom_range(0, 70))
                                                   : {$urandom, $urandom});
        end
        @(negedge clk);
        drain_one();

        // R1: mid-run reset clears the output
        op_i = 4'd9; opa_i = 64'h0;
        rst = 1'b1;
        @(negedge clk);
        check_val("R1", result_o, 64'd0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule